// File: doc/BRIEF.md
# Aliased Set/Clear/Toggle Control Register Bank

This block is a bank of 32-bit control registers on a simple register bus. Each logical register fills a 16-byte slot. Address bits [3:2] inside the slot pick what a write does to the register: replace it, OR data into it, clear the bits that are set in the data, or XOR data into it. Software can therefore change single bits without a separate read-modify-write sequence. A read through any of the four aliases returns the stored value unchanged.

One 64 KB window holds three regions. A main sub-bank starts at 0x060. Its clock-control registers come out of reset with nonzero defaults and a read-only lock status bit set. An auxiliary sub-bank starts at 0x200 and clears to zero. A read-only identification word sits at 0x800. The decoder tests the identification word first, so it wins wherever regions overlap. An access that hits nothing, or that is not 32-bit aligned, reads zero, changes nothing and flags an error.

The bus accepts a request in every cycle. Each accepted request returns a registered response on the next cycle.

Top module: `scr_regbank`

## Requirements
- R1: A write at slot offset 0x0 (op code 0 in address bits [3:2]) replaces the addressed register with the write data.
- R2: A write at slot offset 0x4 (op code 1) ORs the write data into the register.
- R3: A write at slot offset 0x8 (op code 2) clears the register bits that are 1 in the write data.
- R4: A write at slot offset 0xC (op code 3) XORs the write data into the register.
- R5: A read at any of the four aliases of a slot returns the current register value and does not modify it.
- R6: The main sub-bank has 20 registers at 0x060 + 16*i. The auxiliary sub-bank has 8 registers at 0x200 + 16*i. Address bits [3:0] select only the alias.
- R7: The word at 0x800 reads 0x00720010. A write to it is discarded and sets rsp_err in its response.
- R8: After reset, main registers 0, 4, 8, 12 and 16 read 0x80002042, 0x8060302C, 0x80002000, 0x80001FC0 and 0x8001301B. Main register 5 reads 0x06AAAC4D. Every other main register and every auxiliary register reads 0.
- R9: Bit 31 of main registers 0, 4, 8, 12 and 16 is a lock flag that reads 1 after any write, whatever the alias and the data.
- R10: An access outside the three regions, or with address bits [1:0] nonzero, reads 0, leaves every register unchanged and sets rsp_err for that one response.
- R11: req_ready is always 1. Every request taken on a clock edge has rsp_valid high on the next cycle, and rsp_valid and rsp_err are low in cycles after a cycle with no request and after reset.
- R12: Aliased writes to the same register on consecutive cycles compose: each one acts on the result of the one before.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request can be taken (always 1) |
| req_addr | input | 16 | Byte address inside the window |
| req_we | input | 1 | 1 = write, 0 = read |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Response for the previous cycle's request |
| rsp_rdata | output | 32 | Read data (0 for writes and errors) |
| rsp_err | output | 1 | Previous request hit nothing, was unaligned, or wrote the ID word |

## Verification
In a single write cycle, the bitwise alias operation and the lock-flag override both act on the same register bit. Clear and toggle writes with bit 31 set in the data, sent to lock-bearing registers, provoke this. The read that follows must show bit 31 still 1 and the lower bits changed exactly as the alias defines. The second collision is a write landing in the cycle right after another write to the same register. Four aliased writes are issued on consecutive cycles with no gap, and each alias is then read back against a bench model that applies the operations in order.

// File: rtl/scr_pkg.sv
package scr_pkg;

  localparam int          DATA_W   = 32;
  localparam int          LOCK_BIT = 31;
  localparam logic [31:0] ID_VALUE = 32'h0072_0010;

  typedef enum logic [1:0] {
    OP_WRITE  = 2'd0,
    OP_SET    = 2'd1,
    OP_CLEAR  = 2'd2,
    OP_TOGGLE = 2'd3
  } alias_op_e;

  typedef enum logic [1:0] {
    HIT_NONE = 2'd0,
    HIT_MAIN = 2'd1,
    HIT_AUX  = 2'd2,
    HIT_ID   = 2'd3
  } hit_e;

  // clock-control registers carrying a read-only lock flag
  function automatic logic has_lock(input int idx);
    case (idx)
      0, 4, 8, 12, 16: has_lock = 1'b1;
      default:         has_lock = 1'b0;
    endcase
  endfunction

  function automatic logic [31:0] main_default(input int idx);
    logic [31:0] v;
    case (idx)
      0:       v = 32'h0000_2042;
      4:       v = 32'h0060_302C;
      5:       v = 32'h06AA_AC4D;
      8:       v = 32'h0000_2000;
      12:      v = 32'h0000_1FC0;
      16:      v = 32'h0001_301B;
      default: v = 32'h0;
    endcase
    if (has_lock(idx)) v[LOCK_BIT] = 1'b1;
    return v;
  endfunction

  function automatic logic [31:0] alias_apply(input logic [31:0] cur,
                                              input alias_op_e op,
                                              input logic [31:0] data);
    case (op)
      OP_WRITE:  alias_apply = data;
      OP_SET:    alias_apply = cur | data;
      OP_CLEAR:  alias_apply = cur & ~data;
      default:   alias_apply = cur ^ data;
    endcase
  endfunction

endpackage

// File: rtl/scr_addr_decode.sv
module scr_addr_decode
  import scr_pkg::*;
#(
  parameter int ADDR_W    = 16,
  parameter int MAIN_BASE = 'h060,
  parameter int MAIN_REGS = 20,
  parameter int AUX_BASE  = 'h200,
  parameter int AUX_REGS  = 8,
  parameter int ID_ADDR   = 'h800,
  localparam int MIW = (MAIN_REGS > 1) ? $clog2(MAIN_REGS) : 1,
  localparam int AIW = (AUX_REGS > 1) ? $clog2(AUX_REGS) : 1
) (
  input  logic [ADDR_W-1:0] addr,
  output hit_e              hit,
  output logic [MIW-1:0]    main_idx,
  output logic [AIW-1:0]    aux_idx,
  output alias_op_e         op
);

  localparam int SLOT_B  = 16;
  localparam int MAIN_END = MAIN_BASE + MAIN_REGS * SLOT_B;
  localparam int AUX_END  = AUX_BASE + AUX_REGS * SLOT_B;

  logic [31:0] a32, moff, aoff;
  logic        aligned, in_main, in_aux, in_id;

  always_comb begin
    a32     = 32'(addr);
    moff    = a32 - 32'(MAIN_BASE);
    aoff    = a32 - 32'(AUX_BASE);
    aligned = (addr[1:0] == 2'b00);
    in_id   = (a32 == 32'(ID_ADDR));
    in_main = (a32 >= 32'(MAIN_BASE)) && (a32 < 32'(MAIN_END));
    in_aux  = (a32 >= 32'(AUX_BASE)) && (a32 < 32'(AUX_END));
    main_idx = MIW'(moff >> 4);
    aux_idx  = AIW'(aoff >> 4);
    op       = alias_op_e'(addr[3:2]);
    // the identification word is tested first: it wins any overlap
    if (!aligned)     hit = HIT_NONE;
    else if (in_id)   hit = HIT_ID;
    else if (in_main) hit = HIT_MAIN;
    else if (in_aux)  hit = HIT_AUX;
    else              hit = HIT_NONE;
  end

endmodule

// File: rtl/scr_alias_bank.sv
module scr_alias_bank
  import scr_pkg::*;
#(
  parameter int N_REGS       = 20,
  parameter bit USE_DEFAULTS = 1'b1,
  localparam int IDX_W = (N_REGS > 1) ? $clog2(N_REGS) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  alias_op_e         wr_op,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [IDX_W-1:0]  rd_idx,
  output logic [DATA_W-1:0] rd_data
);

  logic [DATA_W-1:0] regs      [N_REGS];
  logic [DATA_W-1:0] rst_val   [N_REGS];
  logic [DATA_W-1:0] lock_mask [N_REGS];

  for (genvar g = 0; g < N_REGS; g++) begin : g_slot
    if (USE_DEFAULTS) begin : g_def
      assign rst_val[g]   = main_default(g);
      assign lock_mask[g] = has_lock(g) ? (DATA_W'(1) << LOCK_BIT) : '0;
    end else begin : g_zero
      assign rst_val[g]   = '0;
      assign lock_mask[g] = '0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < N_REGS; i++) regs[i] <= rst_val[i];
    end else if (wr_en) begin
      regs[wr_idx] <= alias_apply(regs[wr_idx], wr_op, wr_data) | lock_mask[wr_idx];
    end
  end

  assign rd_data = regs[rd_idx];

endmodule

// File: rtl/scr_regbank.sv
module scr_regbank
  import scr_pkg::*;
#(
  parameter int ADDR_W    = 16,
  parameter int MAIN_BASE = 'h060,
  parameter int MAIN_REGS = 20,
  parameter int AUX_BASE  = 'h200,
  parameter int AUX_REGS  = 8,
  parameter int ID_ADDR   = 'h800
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic              req_we,
  input  logic [31:0]       req_wdata,
  output logic              rsp_valid,
  output logic [31:0]       rsp_rdata,
  output logic              rsp_err
);

  localparam int MIW = (MAIN_REGS > 1) ? $clog2(MAIN_REGS) : 1;
  localparam int AIW = (AUX_REGS > 1) ? $clog2(AUX_REGS) : 1;

  hit_e           hit;
  alias_op_e      op;
  logic [MIW-1:0] main_idx;
  logic [AIW-1:0] aux_idx;
  logic [31:0]    main_rd, aux_rd, rd_mux;
  logic           err_now;

  assign req_ready = 1'b1;

  scr_addr_decode #(
    .ADDR_W(ADDR_W), .MAIN_BASE(MAIN_BASE), .MAIN_REGS(MAIN_REGS),
    .AUX_BASE(AUX_BASE), .AUX_REGS(AUX_REGS), .ID_ADDR(ID_ADDR)
  ) u_dec (
    .addr(req_addr), .hit(hit), .main_idx(main_idx), .aux_idx(aux_idx), .op(op)
  );

  scr_alias_bank #(.N_REGS(MAIN_REGS), .USE_DEFAULTS(1'b1)) u_main (
    .clk(clk), .rst(rst),
    .wr_en(req_valid && req_we && hit == HIT_MAIN),
    .wr_idx(main_idx), .wr_op(op), .wr_data(req_wdata),
    .rd_idx(main_idx), .rd_data(main_rd)
  );

  scr_alias_bank #(.N_REGS(AUX_REGS), .USE_DEFAULTS(1'b0)) u_aux (
    .clk(clk), .rst(rst),
    .wr_en(req_valid && req_we && hit == HIT_AUX),
    .wr_idx(aux_idx), .wr_op(op), .wr_data(req_wdata),
    .rd_idx(aux_idx), .rd_data(aux_rd)
  );

  always_comb begin
    rd_mux  = '0;
    err_now = 1'b0;
    case (hit)
      HIT_MAIN: rd_mux = main_rd;
      HIT_AUX:  rd_mux = aux_rd;
      HIT_ID:   begin rd_mux = ID_VALUE; err_now = req_we; end
      default:  err_now = 1'b1;
    endcase
    if (req_we) rd_mux = '0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
      rsp_err   <= 1'b0;
    end else begin
      rsp_valid <= req_valid;
      rsp_rdata <= req_valid ? rd_mux : '0;
      rsp_err   <= req_valid && err_now;
    end
  end

endmodule

// File: rtl/scr_regbank_chk.sv
module scr_regbank_chk
  import scr_pkg::*;
#(
  parameter int ADDR_W = 16
) (
  input logic              clk,
  input logic              rst,
  input logic              req_valid,
  input logic              req_ready,
  input logic [ADDR_W-1:0] req_addr,
  input logic              req_we,
  input logic [31:0]       req_wdata,
  input logic              rsp_valid,
  input logic [31:0]       rsp_rdata,
  input logic              rsp_err
);

  AST_RSP_FOLLOWS_REQ: assert property (@(posedge clk) disable iff (rst)
    req_valid |=> rsp_valid); // R11

  AST_NO_SPURIOUS_RSP: assert property (@(posedge clk) disable iff (rst)
    !req_valid |=> !rsp_valid && !rsp_err); // R11

  AST_ID_READ_VALUE: assert property (@(posedge clk) disable iff (rst)
    req_valid && !req_we && req_addr == ADDR_W'('h800)
      |=> rsp_rdata == ID_VALUE && !rsp_err); // R7

  AST_ID_WRITE_FLAGGED: assert property (@(posedge clk) disable iff (rst)
    req_valid && req_we && req_addr == ADDR_W'('h800) |=> rsp_err); // R7

  AST_UNALIGNED_FLAGGED: assert property (@(posedge clk) disable iff (rst)
    req_valid && req_addr[1:0] != 2'b00 |=> rsp_err && rsp_rdata == '0); // R10

  AST_LOCK_READS_SET: assert property (@(posedge clk) disable iff (rst)
    req_valid && !req_we && req_addr[ADDR_W-1:4] == (ADDR_W-4)'('h6)
      && req_addr[1:0] == 2'b00 |=> rsp_rdata[LOCK_BIT]); // R9

endmodule

bind scr_regbank scr_regbank_chk #(.ADDR_W(ADDR_W)) u_chk (.*);

// File: tb/scr_regbank_tb.sv
module scr_regbank_tb_top;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [15:0] req_addr = '0;
  logic        req_we = 1'b0;
  logic [31:0] req_wdata = '0;
  logic        rsp_valid;
  logic [31:0] rsp_rdata;
  logic        rsp_err;

  int vectors = 0;
  int miscompares = 0;
  logic [31:0] m_main [20];
  logic [31:0] m_aux  [8];

  always #10 clk = ~clk; // 50 MHz

  scr_regbank dut_i (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .req_we(req_we), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .rsp_err(rsp_err)
  );

  function automatic bit pll_reg(int i);
    return (i == 0 || i == 4 || i == 8 || i == 12 || i == 16);
  endfunction

  // 0 none, 1 main, 2 aux, 3 id
  function automatic int region(logic [15:0] a);
    if (a[1:0] != 2'b00) return 0;
    if (a == 16'h0800) return 3;
    if (a >= 16'h0060 && a < 16'h01A0) return 1;
    if (a >= 16'h0200 && a < 16'h0280) return 2;
    return 0;
  endfunction

  function automatic logic [31:0] op_model(logic [31:0] o, logic [1:0] op, logic [31:0] d);
    case (op)
      2'd0: return d;
      2'd1: return o | d;
      2'd2: return o & ~d;
      default: return o ^ d;
    endcase
  endfunction

  task automatic check(bit ok, string tag, logic [31:0] act, logic [31:0] exp);
    vectors++;
    if (!ok) begin
      miscompares++;
      $display("FAIL %s actual=%08h expected=%08h", tag, act, exp);
    end
  endtask

  task automatic model_reset();
    for (int i = 0; i < 20; i++) m_main[i] = 32'h0;
    for (int i = 0; i < 8; i++) m_aux[i] = 32'h0;
    m_main[0]  = 32'h8000_2042;
    m_main[4]  = 32'h8060_302C;
    m_main[5]  = 32'h06AA_AC4D;
    m_main[8]  = 32'h8000_2000;
    m_main[12] = 32'h8000_1FC0;
    m_main[16] = 32'h8001_301B;
  endtask

  // one request; caller-chained calls give back-to-back cycles
  task automatic access(bit we, logic [15:0] a, logic [31:0] d, string tag);
    int r, idx;
    logic [31:0] exp_rd;
    bit exp_err;
    r = region(a);
    exp_rd = 32'h0;
    exp_err = (r == 0) || (r == 3 && we);
    idx = 0;
    if (r == 1) idx = (int'(a) - 'h60) >> 4;
    if (r == 2) idx = (int'(a) - 'h200) >> 4;
    if (!we) begin
      if (r == 1) exp_rd = m_main[idx];
      if (r == 2) exp_rd = m_aux[idx];
      if (r == 3) exp_rd = 32'h0072_0010;
    end
    req_valid = 1'b1; req_we = we; req_addr = a; req_wdata = d;
    @(posedge clk);
    @(negedge clk);
    if (we && r == 1) begin
      m_main[idx] = op_model(m_main[idx], a[3:2], d);
      if (pll_reg(idx)) m_main[idx][31] = 1'b1;
    end
    if (we && r == 2) m_aux[idx] = op_model(m_aux[idx], a[3:2], d);
    check(rsp_valid === 1'b1, {tag, " R11 rsp_valid"}, 32'(rsp_valid), 32'h1);
    check(rsp_err === exp_err, {tag, " err"}, 32'(rsp_err), 32'(exp_err));
    if (!we) check(rsp_rdata === exp_rd, {tag, " rdata"}, rsp_rdata, exp_rd);
  endtask

  task automatic idle();
    req_valid = 1'b0; req_we = 1'b0;
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic sweep(string tag);
    for (int i = 0; i < 20; i++) access(1'b0, 16'(16'h60 + 16 * i), 32'h0, tag);
    for (int i = 0; i < 8; i++) access(1'b0, 16'(16'h200 + 16 * i), 32'h0, tag);
  endtask

  initial begin
    #(20 * 190000);
    miscompares++;
    $display("FAIL watchdog actual=%08h expected=%08h", 32'h0, 32'h1);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    void'($urandom(32'h5EED_1234));
    model_reset();
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check(rsp_valid === 1'b0 && rsp_err === 1'b0, "R11 reset idle", 32'({rsp_valid, rsp_err}), 32'h0);
    check(req_ready === 1'b1, "R11 ready", 32'(req_ready), 32'h1);

    sweep("R8 reset value");

    // R7 id word
    access(1'b0, 16'h0800, 32'h0, "R7 id read");
    access(1'b1, 16'h0800, 32'hFFFF_FFFF, "R7 id write");
    access(1'b0, 16'h0800, 32'h0, "R7 id after write");

    // R9 lock bit kept under every alias
    access(1'b1, 16'h0060, 32'h0000_0000, "R9 plain");
    access(1'b0, 16'h0060, 32'h0, "R9 plain read");
    access(1'b1, 16'h00A8, 32'hFFFF_FFFF, "R9 clear");
    access(1'b0, 16'h00A0, 32'h0, "R9 clear read");
    access(1'b1, 16'h00EC, 32'h8000_0001, "R9 toggle");
    access(1'b0, 16'h00E0, 32'h0, "R9 toggle read");

    // R12 back-to-back aliases, R1..R4, R5 read every alias
    access(1'b1, 16'h0070, 32'h1234_5678, "R1 write");
    access(1'b1, 16'h0074, 32'h0F00_000F, "R2 set");
    access(1'b1, 16'h0078, 32'h0000_5670, "R3 clear");
    access(1'b1, 16'h007C, 32'hFFFF_0000, "R4 toggle");
    access(1'b0, 16'h0070, 32'h0, "R12 R5 alias0");
    access(1'b0, 16'h0074, 32'h0, "R5 alias4");
    access(1'b0, 16'h0078, 32'h0, "R5 alias8");
    access(1'b0, 16'h007C, 32'h0, "R5 aliasC");

    // R6 aux bank extent and last main slot
    access(1'b1, 16'h0270, 32'hCAFE_F00D, "R6 aux last");
    access(1'b1, 16'h0194, 32'h0000_00FF, "R6 main last");
    access(1'b1, 16'h0280, 32'hFFFF_FFFF, "R10 past aux");
    access(1'b1, 16'h01A0, 32'hFFFF_FFFF, "R10 past main");

    // R10 unmapped / unaligned
    access(1'b0, 16'h0000, 32'h0, "R10 unmapped read");
    access(1'b1, 16'h0061, 32'h0000_0000, "R10 unaligned write");
    access(1'b0, 16'h0062, 32'h0, "R10 unaligned read");
    access(1'b1, 16'hFFF0, 32'hFFFF_FFFF, "R10 high write");
    idle();
    check(rsp_valid === 1'b0 && rsp_err === 1'b0, "R11 idle", 32'({rsp_valid, rsp_err}), 32'h0);
    sweep("R10 state kept");

    // random mix
    for (int n = 0; n < 3000; n++) begin
      int k;
      logic [15:0] a;
      k = int'($urandom_range(0, 9));
      if (k < 5)      a = 16'(16'h60 + 16 * $urandom_range(0, 19)) | 16'({$urandom_range(0, 3), 2'b00});
      else if (k < 8) a = 16'(16'h200 + 16 * $urandom_range(0, 7)) | 16'({$urandom_range(0, 3), 2'b00});
      else if (k < 9) a = 16'h0800;
      else            a = 16'($urandom);
      access(1'($urandom), a, $urandom, "R1 R2 R3 R4 R12 random");
      if ($urandom_range(0, 7) == 0) idle();
    end
    sweep("R5 final sweep");

    // R8 reset restores defaults
    req_valid = 1'b0;
    rst = 1'b1;
    @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    model_reset();
    sweep("R8 after re-reset");
    idle();

    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

endmodule